// File: doc/BRIEF.md
# Two-Channel 2-D DMA with Ping-Pong Local Banks

This engine copies blocks of words between an external memory and a local memory that is split into two banks. The core computes out of one bank while the engine fills or drains the other. When both sides are finished, a bank swap hands each side the bank the other side held. The local memory has two planes, one for instructions and one for data, and each transfer names the plane it uses. All addresses are physical word addresses.

Two channels are set up through register-style inputs, and an arm pulse queues a channel. Only one channel runs at a time. The lower-numbered channel wins when both are queued. A transfer is either linear (one row) or a rectangle of rows. On the external side the address advances by an element stride inside a row and by a row stride from one row start to the next. On the local side the address always advances by one word.

The engine is one state machine with these states:
- `ST_IDLE`: waits for work.
- `ST_SWAP`: a one-cycle bank handover.
- `ST_LOAD`: latches the chosen channel's setup into the address generator.
- `ST_READ`: fetches one element from the source side.
- `ST_WRITE`: stores that element on the destination side.
- `ST_FINISH`: raises the channel's done flag.

The transitions are:
- IDLE→SWAP when a swap is pending.
- IDLE→LOAD when no swap is pending and a channel is queued.
- SWAP→IDLE.
- LOAD→READ.
- READ→WRITE once the read is accepted.
- WRITE→READ once the write is accepted, unless that element was the last one.
- WRITE→FINISH once the write of the last element is accepted.
- FINISH→IDLE.

Top module: `dma2d_pingpong`

## Requirements
- R1: After reset the engine is idle, `core_bank` is 0, all done flags are 0, and neither `ext_req` nor `lm_req` is asserted.
- R2: A linear transfer (`cfg_2d`=0) moves `cfg_elems_m1`+1 elements, which is the field value plus one. Element i is read from external address `ext_base + i*elem_stride` (modulo 2^AW). It is written to local address `loc_base + i`. A stride of 1 means contiguous words.
- R3: A rectangular transfer (`cfg_2d`=1) moves `rows_m1+1` rows of `elems_m1+1` elements. Element i of row j uses external address `ext_base + j*row_stride + i*elem_stride` and local address `loc_base + j*(elems_m1+1) + i`. Rows are walked in order, and elements within a row are walked in order.
- R4: `cfg_dir`=1 reverses the direction: the local memory is the source and the external memory is the destination, with the same address rules.
- R5: `cfg_imem`=1 routes every local access of the transfer to the instruction plane (`lm_imem`=1). `cfg_imem`=0 routes them to the data plane.
- R6: Every local access by the engine uses the bank the core does not own (`lm_bank` = !`core_bank`). The core-owned bank is never written.
- R7: A `swap_req` pulse toggles `core_bank`, but only while no transfer runs. A request that arrives during a transfer is held and takes effect after that transfer, before the next channel starts.
- R8: When several channels are queued, the lowest-numbered channel runs first. Channel 1 starts only after channel 0 raised done.
- R9: A channel's done flag rises after its final element is written. It stays set until that channel is armed again, and arming clears it on the following cycle.
- R10: While `ext_req` is high and `ext_ready` is low, the request, address, write enable and write data hold steady. The engine never accesses both memories in the same cycle.
- R11: In linear mode the row count and the row stride have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| arm | input | NCH | Per-channel start pulse |
| cfg_dir | input | NCH | 0: external to local, 1: local to external |
| cfg_imem | input | NCH | 1: instruction plane, 0: data plane |
| cfg_2d | input | NCH | 1: rectangular transfer |
| cfg_ext_base | input | NCH x AW | External start address |
| cfg_loc_base | input | NCH x LAW | Local start address |
| cfg_elems_m1 | input | NCH x CW | Elements per row minus one |
| cfg_rows_m1 | input | NCH x CW | Rows minus one |
| cfg_elem_stride | input | NCH x AW | External step between elements |
| cfg_row_stride | input | NCH x AW | External step between row starts |
| swap_req | input | 1 | Bank swap request pulse |
| core_bank | output | 1 | Bank currently owned by the core |
| busy | output | 1 | A transfer is in progress |
| active_ch | output | CHW | Running channel (valid while busy) |
| done | output | NCH | Per-channel completion flags |
| ext_req | output | 1 | External access request |
| ext_we | output | 1 | External write enable |
| ext_addr | output | AW | External word address |
| ext_wdata | output | DW | External write data |
| ext_rdata | input | DW | External read data, valid with ready |
| ext_ready | input | 1 | External access accepted |
| lm_req | output | 1 | Local access (always accepted in one cycle) |
| lm_we | output | 1 | Local write enable |
| lm_imem | output | 1 | Local plane select |
| lm_bank | output | 1 | Local bank select |
| lm_addr | output | LAW | Local word address |
| lm_wdata | output | DW | Local write data |
| lm_rdata | input | DW | Local read data, same cycle |

## Verification
The bench builds the engine with a 12-bit external address, a 6-bit local address (64 words per bank) and 4-bit count fields. With these values a full 8x8 rectangle fills a bank exactly, and external strides wrap within a small model memory. The count fields reach 16 elements, so the done and last-element logic is exercised at both the single-element and the full-bank limits. Random acceptance delays on the external port stretch transfers long enough to place swap requests and second-channel arms in the middle of a running transfer.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SWAP,
        ST_LOAD,
        ST_READ,
        ST_WRITE,
        ST_FINISH
    } dma_state_t;

    typedef enum logic {
        DIR_TO_LOCAL = 1'b0,
        DIR_TO_EXT   = 1'b1
    } dma_dir_t;

endpackage

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen #(
    parameter int AW  = 16,
    parameter int LAW = 8,
    parameter int CW  = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           step,
    input  logic           mode_2d,
    input  logic [AW-1:0]  ext_base,
    input  logic [LAW-1:0] loc_base,
    input  logic [CW-1:0]  elems_m1,
    input  logic [CW-1:0]  rows_m1,
    input  logic [AW-1:0]  elem_stride,
    input  logic [AW-1:0]  row_stride,
    output logic [AW-1:0]  ext_addr,
    output logic [LAW-1:0] loc_addr,
    output logic           last
);

    logic [AW-1:0]  ext_q, row_start_q, es_q, rs_q;
    logic [LAW-1:0] loc_q;
    logic [CW-1:0]  ecnt_q, rcnt_q, elems_q, rows_q;
    logic           row_end;

    assign row_end  = (ecnt_q == elems_q);
    assign last     = row_end && (rcnt_q == rows_q);
    assign ext_addr = ext_q;
    assign loc_addr = loc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ext_q       <= '0;
            row_start_q <= '0;
            es_q        <= '0;
            rs_q        <= '0;
            loc_q       <= '0;
            ecnt_q      <= '0;
            rcnt_q      <= '0;
            elems_q     <= '0;
            rows_q      <= '0;
        end else if (load) begin
            ext_q       <= ext_base;
            row_start_q <= ext_base;
            es_q        <= elem_stride;
            rs_q        <= row_stride;
            loc_q       <= loc_base;
            ecnt_q      <= '0;
            rcnt_q      <= '0;
            elems_q     <= elems_m1;
            rows_q      <= mode_2d ? rows_m1 : '0;
        end else if (step) begin
            loc_q <= loc_q + 1'b1;
            if (row_end) begin
                ecnt_q      <= '0;
                rcnt_q      <= rcnt_q + 1'b1;
                row_start_q <= row_start_q + rs_q;
                ext_q       <= row_start_q + rs_q;
            end else begin
                ecnt_q <= ecnt_q + 1'b1;
                ext_q  <= ext_q + es_q;
            end
        end
    end

endmodule

// File: rtl/dma2d_bank_ctl.sv
module dma2d_bank_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic swap_req,
    input  logic swap_go,
    output logic core_bank,
    output logic swap_pend
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_bank <= 1'b0;
            swap_pend <= 1'b0;
        end else begin
            swap_pend <= (swap_pend && !swap_go) || swap_req;
            if (swap_go) begin
                core_bank <= !core_bank;
            end
        end
    end

endmodule

// File: rtl/dma2d_chan_arb.sv
module dma2d_chan_arb #(
    parameter int NCH = 2,
    parameter int CHW = 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] arm,
    input  logic           start,
    input  logic           finish,
    input  logic [CHW-1:0] run_ch,
    output logic           any_pend,
    output logic [CHW-1:0] grant,
    output logic [NCH-1:0] done
);

    logic [NCH-1:0] pend_q;

    always_comb begin
        grant = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (pend_q[i]) begin
                grant = CHW'(i);
            end
        end
    end

    assign any_pend = |pend_q;

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pend_q[c] <= 1'b0;
                done[c]   <= 1'b0;
            end else begin
                if (arm[c]) begin
                    pend_q[c] <= 1'b1;
                end else if (start && (grant == CHW'(c))) begin
                    pend_q[c] <= 1'b0;
                end
                if (arm[c]) begin
                    done[c] <= 1'b0;
                end else if (finish && (run_ch == CHW'(c))) begin
                    done[c] <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/dma2d_pingpong.sv
module dma2d_pingpong
    import dma2d_pkg::*;
#(
    parameter int NCH = 2,
    parameter int AW  = 16,
    parameter int LAW = 8,
    parameter int CW  = 8,
    parameter int DW  = 32,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NCH-1:0]           arm,
    input  logic [NCH-1:0]           cfg_dir,
    input  logic [NCH-1:0]           cfg_imem,
    input  logic [NCH-1:0]           cfg_2d,
    input  logic [NCH-1:0][AW-1:0]   cfg_ext_base,
    input  logic [NCH-1:0][LAW-1:0]  cfg_loc_base,
    input  logic [NCH-1:0][CW-1:0]   cfg_elems_m1,
    input  logic [NCH-1:0][CW-1:0]   cfg_rows_m1,
    input  logic [NCH-1:0][AW-1:0]   cfg_elem_stride,
    input  logic [NCH-1:0][AW-1:0]   cfg_row_stride,
    input  logic                     swap_req,
    output logic                     core_bank,
    output logic                     busy,
    output logic [CHW-1:0]           active_ch,
    output logic [NCH-1:0]           done,
    output logic                     ext_req,
    output logic                     ext_we,
    output logic [AW-1:0]            ext_addr,
    output logic [DW-1:0]            ext_wdata,
    input  logic [DW-1:0]            ext_rdata,
    input  logic                     ext_ready,
    output logic                     lm_req,
    output logic                     lm_we,
    output logic                     lm_imem,
    output logic                     lm_bank,
    output logic [LAW-1:0]           lm_addr,
    output logic [DW-1:0]            lm_wdata,
    input  logic [DW-1:0]            lm_rdata
);

    dma_state_t     state_q, state_d;
    logic [CHW-1:0] sel_q, grant;
    dma_dir_t       dir_q;
    logic           imem_q;
    logic [DW-1:0]  data_q;
    logic           swap_pend, swap_go, any_pend, start, finish;
    logic           load, step, last, accept;

    dma2d_bank_ctl u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .swap_req  (swap_req),
        .swap_go   (swap_go),
        .core_bank (core_bank),
        .swap_pend (swap_pend)
    );

    dma2d_chan_arb #(.NCH(NCH), .CHW(CHW)) u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (arm),
        .start    (start),
        .finish   (finish),
        .run_ch   (sel_q),
        .any_pend (any_pend),
        .grant    (grant),
        .done     (done)
    );

    dma2d_addr_gen #(.AW(AW), .LAW(LAW), .CW(CW)) u_agen (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (load),
        .step        (step),
        .mode_2d     (cfg_2d[sel_q]),
        .ext_base    (cfg_ext_base[sel_q]),
        .loc_base    (cfg_loc_base[sel_q]),
        .elems_m1    (cfg_elems_m1[sel_q]),
        .rows_m1     (cfg_rows_m1[sel_q]),
        .elem_stride (cfg_elem_stride[sel_q]),
        .row_stride  (cfg_row_stride[sel_q]),
        .ext_addr    (ext_addr),
        .loc_addr    (lm_addr),
        .last        (last)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (swap_pend) begin
                    state_d = ST_SWAP;
                end else if (any_pend) begin
                    state_d = ST_LOAD;
                end
            end
            ST_SWAP:   state_d = ST_IDLE;
            ST_LOAD:   state_d = ST_READ;
            ST_READ:   if (accept) state_d = ST_WRITE;
            ST_WRITE:  if (accept) state_d = last ? ST_FINISH : ST_READ;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs and strobes
    always_comb begin
        ext_req = 1'b0;
        ext_we  = 1'b0;
        lm_req  = 1'b0;
        lm_we   = 1'b0;
        unique case (state_q)
            ST_READ: begin
                ext_req = (dir_q == DIR_TO_LOCAL);
                lm_req  = (dir_q == DIR_TO_EXT);
            end
            ST_WRITE: begin
                ext_req = (dir_q == DIR_TO_EXT);
                ext_we  = (dir_q == DIR_TO_EXT);
                lm_req  = (dir_q == DIR_TO_LOCAL);
                lm_we   = (dir_q == DIR_TO_LOCAL);
            end
            default: ;
        endcase
        accept  = ext_req ? ext_ready : 1'b1;
        start   = (state_q == ST_IDLE) && !swap_pend && any_pend;
        swap_go = (state_q == ST_SWAP);
        load    = (state_q == ST_LOAD);
        step    = (state_q == ST_WRITE) && accept;
        finish  = (state_q == ST_FINISH);
        busy    = (state_q == ST_LOAD) || (state_q == ST_READ) ||
                  (state_q == ST_WRITE) || (state_q == ST_FINISH);
    end

    assign active_ch = sel_q;
    assign lm_imem   = imem_q;
    assign lm_bank   = !core_bank;
    assign ext_wdata = data_q;
    assign lm_wdata  = data_q;

    // channel latch and element buffer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q  <= '0;
            dir_q  <= DIR_TO_LOCAL;
            imem_q <= 1'b0;
            data_q <= '0;
        end else begin
            if (start) begin
                sel_q <= grant;
            end
            if (load) begin
                dir_q  <= dma_dir_t'(cfg_dir[sel_q]);
                imem_q <= cfg_imem[sel_q];
            end
            if ((state_q == ST_READ) && accept) begin
                data_q <= (dir_q == DIR_TO_LOCAL) ? ext_rdata : lm_rdata;
            end
        end
    end

endmodule

// File: rtl/dma2d_pingpong_chk.sv
module dma2d_pingpong_chk #(
    parameter int NCH = 2,
    parameter int AW  = 16,
    parameter int DW  = 32
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NCH-1:0] arm,
    input logic [NCH-1:0] done,
    input logic           busy,
    input logic           core_bank,
    input logic           ext_req,
    input logic           ext_we,
    input logic           ext_ready,
    input logic [AW-1:0]  ext_addr,
    input logic [DW-1:0]  ext_wdata,
    input logic           lm_req,
    input logic           lm_bank
);

    AST_BANK_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        lm_req |-> (lm_bank != core_bank)); // R6

    AST_SWAP_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(core_bank) |-> !$past(busy)); // R7

    AST_EXT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_req && !ext_ready) |=> (ext_req && $stable(ext_addr) &&
                                     $stable(ext_we) && $stable(ext_wdata))); // R10

    AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ext_req, lm_req})); // R10

    for (genvar c = 0; c < NCH; c++) begin : g_done
        AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            arm[c] |=> !done[c]); // R9
    end

endmodule

bind dma2d_pingpong dma2d_pingpong_chk #(.NCH(NCH), .AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm       (arm),
    .done      (done),
    .busy      (busy),
    .core_bank (core_bank),
    .ext_req   (ext_req),
    .ext_we    (ext_we),
    .ext_ready (ext_ready),
    .ext_addr  (ext_addr),
    .ext_wdata (ext_wdata),
    .lm_req    (lm_req),
    .lm_bank   (lm_bank)
);

// File: tb/dma2d_pingpong_tb.sv
module dma2d_pingpong_tb;

    localparam int NCH = 2;
    localparam int AW  = 12;
    localparam int LAW = 6;
    localparam int CW  = 4;
    localparam int DW  = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = !clk;

    logic [NCH-1:0]          arm = '0;
    logic [NCH-1:0]          cfg_dir = '0, cfg_imem = '0, cfg_2d = '0;
    logic [NCH-1:0][AW-1:0]  cfg_ext_base = '0, cfg_elem_stride = '0, cfg_row_stride = '0;
    logic [NCH-1:0][LAW-1:0] cfg_loc_base = '0;
    logic [NCH-1:0][CW-1:0]  cfg_elems_m1 = '0, cfg_rows_m1 = '0;
    logic                    swap_req = 1'b0;
    logic                    core_bank, busy, ext_req, ext_we, ext_ready;
    logic [0:0]              active_ch;
    logic [NCH-1:0]          done;
    logic [AW-1:0]           ext_addr;
    logic [DW-1:0]           ext_wdata, ext_rdata, lm_wdata, lm_rdata;
    logic                    lm_req, lm_we, lm_imem, lm_bank;
    logic [LAW-1:0]          lm_addr;

    dma2d_pingpong #(.NCH(NCH), .AW(AW), .LAW(LAW), .CW(CW), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .arm(arm), .cfg_dir(cfg_dir), .cfg_imem(cfg_imem),
        .cfg_2d(cfg_2d), .cfg_ext_base(cfg_ext_base), .cfg_loc_base(cfg_loc_base),
        .cfg_elems_m1(cfg_elems_m1), .cfg_rows_m1(cfg_rows_m1),
        .cfg_elem_stride(cfg_elem_stride), .cfg_row_stride(cfg_row_stride),
        .swap_req(swap_req), .core_bank(core_bank), .busy(busy), .active_ch(active_ch),
        .done(done), .ext_req(ext_req), .ext_we(ext_we), .ext_addr(ext_addr),
        .ext_wdata(ext_wdata), .ext_rdata(ext_rdata), .ext_ready(ext_ready),
        .lm_req(lm_req), .lm_we(lm_we), .lm_imem(lm_imem), .lm_bank(lm_bank),
        .lm_addr(lm_addr), .lm_wdata(lm_wdata), .lm_rdata(lm_rdata)
    );

    // memory models
    logic [DW-1:0] ext_mem [0:4095];
    logic [DW-1:0] lm_mem  [0:255];
    int            ready_pct = 100;

    function automatic int lidx(input logic im, input logic bk, input int a);
        return {im, bk, a[5:0]};
    endfunction

    assign ext_rdata = ext_mem[ext_addr];
    assign lm_rdata  = lm_mem[lidx(lm_imem, lm_bank, int'(lm_addr))];

    always @(posedge clk) begin
        if (ext_req && ext_we && ext_ready) ext_mem[ext_addr] <= ext_wdata;
        if (lm_req && lm_we) lm_mem[lidx(lm_imem, lm_bank, int'(lm_addr))] <= lm_wdata;
    end

    always @(negedge clk) ext_ready <= (($urandom % 100) < ready_pct);

    // scoreboard
    int n_tests = 0, n_fail = 0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R10 port monitor
    logic          hold_prev = 1'b0;
    logic [AW-1:0] addr_prev;
    int            hold_bad = 0;
    always @(posedge clk) begin
        if (rst_n && hold_prev && (!ext_req || ext_addr != addr_prev)) hold_bad++;
        hold_prev <= ext_req && !ext_ready;
        addr_prev <= ext_addr;
    end

    // R8 ordering monitor
    bit order_watch = 0;
    int order_bad = 0;
    always @(negedge clk)
        if (order_watch && busy && active_ch == 1'b1 && !done[0]) order_bad++;

    bit exp_bank = 0;

    function automatic logic [DW-1:0] pat(input int k, input int salt);
        return 32'hA500_0000 ^ (k * 32'h9E37) ^ (salt << 20);
    endfunction

    task automatic fill_mems(input int salt);
        for (int k = 0; k < 4096; k++) ext_mem[k] = pat(k, salt);
        for (int k = 0; k < 256; k++) lm_mem[k] = 32'hDEAD_0000 | k;
    endtask

    task automatic setup(input int c, input bit dir, input bit im, input bit two_d,
                         input int eb, input int lb, input int em1, input int rm1,
                         input int es, input int rs);
        cfg_dir[c] = dir; cfg_imem[c] = im; cfg_2d[c] = two_d;
        cfg_ext_base[c] = AW'(eb); cfg_loc_base[c] = LAW'(lb);
        cfg_elems_m1[c] = CW'(em1); cfg_rows_m1[c] = CW'(rm1);
        cfg_elem_stride[c] = AW'(es); cfg_row_stride[c] = AW'(rs);
    endtask

    task automatic pulse_arm(input logic [NCH-1:0] m);
        @(negedge clk); arm = m;
        @(negedge clk); arm = '0;
    endtask

    task automatic wait_done(input int c);
        int t = 0;
        while (!done[c] && t < 5000) begin @(negedge clk); t++; end
        check(done[c] == 1'b1, "R9 done raised", done[c], 1);
    endtask

    // compare memories against the address rules; bank = bank the engine used
    task automatic verify(input int c, input bit bank, input string req);
        int  ne   = int'(cfg_elems_m1[c]) + 1;
        int  nr   = cfg_2d[c] ? int'(cfg_rows_m1[c]) + 1 : 1;
        int  bad  = 0;
        int  lb   = int'(cfg_loc_base[c]);
        logic [DW-1:0] a_v = '0, e_v = '0;
        for (int j = 0; j < nr; j++) begin
            for (int i = 0; i < ne; i++) begin
                int ea = (int'(cfg_ext_base[c]) + j * int'(cfg_row_stride[c]) +
                          i * int'(cfg_elem_stride[c])) % 4096;
                int li = lidx(cfg_imem[c], bank, lb + j * ne + i);
                if (ext_mem[ea] != lm_mem[li] && bad == 0) begin
                    a_v = cfg_dir[c] ? ext_mem[ea] : lm_mem[li];
                    e_v = cfg_dir[c] ? lm_mem[li] : ext_mem[ea];
                end
                if (ext_mem[ea] != lm_mem[li]) bad++;
            end
        end
        check(bad == 0, req, a_v, e_v);
        if (!cfg_dir[c] && lb + ne * nr < 64) begin
            int k = lidx(cfg_imem[c], bank, lb + ne * nr);
            check(lm_mem[k] == (32'hDEAD_0000 | k), "R11 no write past end", lm_mem[k], 32'hDEAD_0000 | k);
        end
        if (!cfg_dir[c]) begin
            int k = lidx(cfg_imem[c], !bank, lb);
            check(lm_mem[k] == (32'hDEAD_0000 | k), "R6 core bank untouched", lm_mem[k], 32'hDEAD_0000 | k);
        end
    endtask

    task automatic run_one(input int c, input string req);
        pulse_arm(NCH'(1 << c));
        wait_done(c);
        @(negedge clk);
        verify(c, !exp_bank, req);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        void'($urandom(32'h1234_5678));
        fill_mems(0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(core_bank == 1'b0, "R1 core_bank", core_bank, 0);
        check(done == '0, "R1 done", done, 0);
        check(!busy && !ext_req && !lm_req, "R1 quiet", {busy, ext_req, lm_req}, 0);

        // R2 contiguous and strided linear, with R11 junk row fields
        setup(0, 0, 0, 0, 100, 3, 9, 5, 1, 77);
        run_one(0, "R2 linear contiguous");
        fill_mems(1);
        ready_pct = 60;
        setup(0, 0, 0, 0, 4090, 10, 7, 15, 3, 500);
        run_one(0, "R11 linear strided wrap ignores rows");

        // R3 rectangle
        fill_mems(2);
        setup(1, 0, 0, 1, 200, 0, 3, 4, 2, 40);
        run_one(1, "R3 rectangle");

        // R4 local to external
        fill_mems(3);
        setup(0, 1, 0, 1, 1000, 5, 2, 3, 1, 16);
        run_one(0, "R4 local to external");

        // R5 instruction plane
        fill_mems(4);
        setup(0, 0, 1, 1, 50, 8, 1, 1, 5, 9);
        run_one(0, "R5 instruction plane");
        check(lm_mem[lidx(0, !exp_bank, 8)] == (32'hDEAD_0000 | lidx(0, !exp_bank, 8)),
              "R5 data plane untouched", lm_mem[lidx(0, !exp_bank, 8)], 32'hDEAD_0000 | lidx(0, !exp_bank, 8));

        // R9 re-arm clears done
        @(negedge clk); arm = 2'b01;
        @(negedge clk); arm = '0;
        check(done[0] == 1'b0, "R9 done cleared by arm", done[0], 0);
        wait_done(0);

        // R7 swap while idle
        @(negedge clk); swap_req = 1'b1;
        @(negedge clk); swap_req = 1'b0;
        repeat (3) @(negedge clk);
        exp_bank = !exp_bank;
        check(core_bank == exp_bank, "R7 idle swap", core_bank, exp_bank);

        // R7 swap held during transfer
        fill_mems(5);
        ready_pct = 30;
        setup(0, 0, 0, 1, 300, 0, 7, 7, 1, 64);
        pulse_arm(2'b01);
        repeat (4) @(negedge clk);
        swap_req = 1'b1; @(negedge clk); swap_req = 1'b0;
        repeat (6) @(negedge clk);
        check(busy == 1'b1, "R7 transfer still running", busy, 1);
        check(core_bank == exp_bank, "R7 swap held", core_bank, exp_bank);
        wait_done(0);
        repeat (3) @(negedge clk);
        check(core_bank == !exp_bank, "R7 swap after transfer", core_bank, !exp_bank);
        verify(0, !exp_bank, "R7 data in pre-swap engine bank");
        exp_bank = !exp_bank;

        // R8 both armed
        fill_mems(6);
        ready_pct = 70;
        setup(0, 0, 0, 1, 10, 0, 3, 3, 1, 20);
        setup(1, 0, 1, 0, 600, 0, 11, 0, 2, 0);
        order_watch = 1;
        pulse_arm(2'b11);
        wait_done(1);
        check(done[0] == 1'b1, "R8 channel 0 done", done[0], 1);
        order_watch = 0;
        check(order_bad == 0, "R8 order", order_bad, 0);
        verify(0, !exp_bank, "R8 channel 0 data");
        verify(1, !exp_bank, "R8 channel 1 data");

        // random transfers
        for (int n = 0; n < 24; n++) begin
            int c   = $urandom % 2;
            int em1 = $urandom % 8;
            int rm1 = $urandom % 8;
            bit two = $urandom % 2;
            int tot = (em1 + 1) * (two ? rm1 + 1 : 1);
            int es  = 1 + $urandom % 4;
            int rs  = (em1 + 1) * es + $urandom % 8;
            fill_mems(10 + n);
            ready_pct = 40 + $urandom % 61;
            setup(c, $urandom % 2, $urandom % 2, two, $urandom % 4096,
                  $urandom % (64 - tot + 1), em1, rm1, es, rs);
            run_one(c, two ? "R3 random rectangle" : "R2 random linear");
        end

        check(hold_bad == 0, "R10 request held until ready", hold_bad, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule